// File: doc/BRIEF.md
# Dual-Identity Two-Wire Register Target

This block is a two-wire (I2C) target that runs entirely on the system clock. It oversamples the serial clock and data lines and recognises START and STOP conditions. It accepts two separate 7-bit device identifiers. One opens a control/status window and the other opens a user-memory window. Both windows are reached through a single register port, which carries a window select, a byte address, write data with a one-cycle write strobe, and read data that the surrounding logic returns combinationally.

A write sends an identifier with the direction bit clear, one word-address byte, and any number of data bytes. A read sends an identifier with the direction bit set. It can follow a dummy write that only loads the address, after a repeated START. One byte pointer serves both directions. It advances once per data byte and wraps from a parameterised last address back to zero.

The open-drain data line is modelled as an output enable. A 1 on that enable pulls the line low.

Top module: `dual_id_i2c_target`

## Requirements
- R1: Nothing is acknowledged until a START (data falling while clock is high) has been seen. A STOP (data rising while clock is high) returns the target to idle from any state, after which bytes clocked without a new START are not acknowledged.
- R2: An identification byte whose upper 7 bits are 1101111 is acknowledged and sets `reg_sel` to 0 (control/status window).
- R3: An identification byte whose upper 7 bits are 1010111 is acknowledged and sets `reg_sel` to 1 (user memory window). Any other identifier gets no acknowledge, and no byte after it is acknowledged until the next START.
- R4: With bit 0 of the identification byte at 0 (write), the next byte loads the pointer and each further byte is acknowledged. Each data byte raises `reg_we` for exactly one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R5: During a multi-byte write the pointer advances by one after each data byte and goes from 2Fh to 00h.
- R6: With bit 0 of the identification byte at 1 (read), the target sends `reg_rdata` for the current pointer MSB first and releases the data line during the ninth clock.
- R7: While the master acknowledges, read bytes continue from an incrementing pointer that wraps 2Fh to 00h. After a master not-acknowledge the target leaves the data line released until the next START or STOP.
- R8: In a random read, a read-phase identifier that differs from the one used in the dummy-write phase of the same transaction is not acknowledged.
- R9: After reset the pointer is 00h, so a read without a preceding address byte starts at address 00h.
- R10: A START seen while `powerup_busy` is high is ignored.
- R11: `sda_oe` changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| powerup_busy | input | 1 | High while the power-up sequence is running; START is ignored |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_sel | output | 1 | Window select: 0 control/status, 1 user memory |
| reg_addr | output | 8 | Byte pointer presented to the register port |
| reg_wdata | output | 8 | Write data for the strobed byte |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_sel`/`reg_addr` |

## Verification
The hardest situations to reach from the ports are the pointer wrap in both directions and the identifier-mismatch rule. Each needs a complete multi-byte transaction with a repeated START in the middle. The bench bit-bangs the bus and loads the pointer with 2Eh through a dummy write, so that a three-byte burst crosses 2Fh. It then repeats the dummy write and switches to the other window's identifier for the read phase. Read data comes from an address-dependent bench function, so a byte from the wrong address or the wrong window shows up directly.

// File: rtl/dual_id_i2c_pkg.sv
package dual_id_i2c_pkg;

  localparam int WORD_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID,
    ST_ID_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } tgt_state_t;

  // next pointer value: +1, or back to zero once the last address is reached
  function automatic logic [WORD_W-1:0] ptr_advance(input logic [WORD_W-1:0] p,
                                                    input logic [WORD_W-1:0] last);
    return (p >= last) ? '0 : p + 1'b1;
  endfunction

  // returns {hit, window}
  function automatic logic [1:0] id_lookup(input logic [6:0] id,
                                           input logic [6:0] ctl_id,
                                           input logic [6:0] mem_id);
    if (id == ctl_id) return 2'b10;
    if (id == mem_id) return 2'b11;
    return 2'b00;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit
  import dual_id_i2c_pkg::*;
#(
  parameter logic [WORD_W-1:0] PTR_LAST = 8'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              step,
  output logic [WORD_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr_advance(ptr, PTR_LAST);
  end
endmodule

// File: rtl/dual_id_i2c_target.sv
module dual_id_i2c_target
  import dual_id_i2c_pkg::*;
#(
  parameter logic [6:0]        CTL_ID      = 7'b1101111,
  parameter logic [6:0]        MEM_ID      = 7'b1010111,
  parameter logic [WORD_W-1:0] PTR_LAST    = 8'h2F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              powerup_busy,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_sel,
  output logic [WORD_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [WORD_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  // named internal events
  wire scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  wire start_taken;
  wire in_idle;
  wire byte_full;
  logic ptr_load, ptr_step;
  logic [1:0] id_res;
  logic id_ok;

  tgt_state_t        st;
  logic [CNT_W-1:0]  bcnt;
  logic [WORD_W-1:0] rx_sh, tx_sh;
  logic              rw_q, m_ack, oe_q, we_q, sel_q;
  logic [6:0]        pend_id;
  logic              pend_v;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_ptr_unit #(.PTR_LAST(PTR_LAST)) ptr_i (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(rx_sh),
    .step(ptr_step), .ptr(ptr)
  );

  assign start_taken = bus_start & ~powerup_busy;
  assign in_idle     = (st == ST_IDLE);
  assign byte_full   = (bcnt == FULL);

  // identifier check: known identifier, and a read after a dummy write keeps it
  always_comb begin
    id_res = id_lookup(rx_sh[7:1], CTL_ID, MEM_ID);
    id_ok  = id_res[1] & (~rx_sh[0] | ~pend_v | (rx_sh[7:1] == pend_id));
  end

  always_comb begin
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    if (!bus_stop && !start_taken && scl_fall) begin
      ptr_load = (st == ST_ADDR) && byte_full;
      ptr_step = (st == ST_WDATA_ACK) || ((st == ST_TX) && byte_full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rw_q    <= 1'b0;
      m_ack   <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      sel_q   <= 1'b0;
      pend_id <= '0;
      pend_v  <= 1'b0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (bus_stop) begin
        st     <= ST_IDLE;
        oe_q   <= 1'b0;
        pend_v <= 1'b0;
      end else if (start_taken) begin
        st   <= ST_ID;
        bcnt <= '0;
        oe_q <= 1'b0;
      end else begin
        unique case (st)
          ST_ID, ST_ADDR, ST_WDATA: begin
            if (scl_rise && !byte_full) begin
              rx_sh <= {rx_sh[WORD_W-2:0], sda_lvl};
              bcnt  <= bcnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (st == ST_ID) begin
                if (id_ok) begin
                  oe_q  <= 1'b1;
                  rw_q  <= rx_sh[0];
                  sel_q <= id_res[0];
                  if (!rx_sh[0]) pend_id <= rx_sh[7:1];
                  st    <= ST_ID_ACK;
                end else begin
                  st <= ST_WAIT;
                end
              end else if (st == ST_ADDR) begin
                oe_q   <= 1'b1;
                pend_v <= 1'b1;
                st     <= ST_ADDR_ACK;
              end else begin
                oe_q    <= 1'b1;
                we_q    <= 1'b1;
                wdata_q <= rx_sh;
                st      <= ST_WDATA_ACK;
              end
            end
          end
          ST_ID_ACK: if (scl_fall) begin
            bcnt <= '0;
            if (rw_q) begin
              tx_sh <= reg_rdata;
              oe_q  <= ~reg_rdata[WORD_W-1];
              st    <= ST_TX;
            end else begin
              oe_q <= 1'b0;
              st   <= ST_ADDR;
            end
          end
          ST_ADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            bcnt <= '0;
            oe_q <= 1'b0;
            st   <= ST_WDATA;
          end
          ST_TX: begin
            if (scl_rise) bcnt <= bcnt + 1'b1;
            else if (scl_fall) begin
              if (byte_full) begin
                oe_q <= 1'b0;
                st   <= ST_MACK;
              end else begin
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                oe_q  <= ~tx_sh[WORD_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) m_ack <= ~sda_lvl;
            else if (scl_fall) begin
              if (m_ack) begin
                bcnt  <= '0;
                tx_sh <= reg_rdata;
                oe_q  <= ~reg_rdata[WORD_W-1];
                st    <= ST_TX;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_sel   = sel_q;
  assign reg_addr  = ptr;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
endmodule

// File: rtl/dual_id_i2c_target_chk.sv
module dual_id_i2c_target_chk #(
  parameter logic [7:0] PTR_LAST = 8'h2F
) (
  input logic       clk,
  input logic       rst_n,
  input logic       powerup_busy,
  input logic       in_idle,
  input logic       scl_lvl,
  input logic       bus_start,
  input logic       bus_stop,
  input logic       sda_oe,
  input logic       reg_we,
  input logic       ptr_step,
  input logic [7:0] reg_addr
);
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> in_idle);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && reg_addr >= PTR_LAST) |=> (reg_addr == 8'h00));

  p_pu_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (powerup_busy && in_idle) |=> in_idle);

  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_lvl) || $past(bus_start) || $past(bus_stop)));
endmodule

bind dual_id_i2c_target dual_id_i2c_target_chk #(.PTR_LAST(PTR_LAST)) chk_i (
  .clk(clk), .rst_n(rst_n), .powerup_busy(powerup_busy), .in_idle(in_idle),
  .scl_lvl(scl_lvl), .bus_start(bus_start), .bus_stop(bus_stop), .sda_oe(sda_oe),
  .reg_we(reg_we), .ptr_step(ptr_step), .reg_addr(reg_addr)
);

// File: tb/dual_id_i2c_target_tb_top.sv
module dual_id_i2c_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, powerup_busy = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_sel, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  int wn = 0;
  logic [7:0] w_addr [16];
  logic [7:0] w_data [16];
  logic       w_sel  [16];
  int oe_viol = 0;
  logic oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_rd(input logic s, input logic [7:0] a);
    return {s, a[6:0]} ^ 8'hA5;
  endfunction
  assign reg_rdata = model_rd(reg_sel, reg_addr);

  dual_id_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .powerup_busy(powerup_busy), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(negedge clk) begin
    if (reg_we && wn < 16) begin
      w_addr[wn] = reg_addr; w_data[wn] = reg_wdata; w_sel[wn] = reg_sel;
    end
    if (reg_we) wn++;
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n*Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = (sda_bus === 1'b0);
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0;
    end
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
    chk(reg_we == 1'b0, "R9 reset reg_we", reg_we, 0);
    chk(reg_addr == 8'h00, "R9 reset pointer", reg_addr, 0);
  endtask

  task automatic t_no_start();
    bit a;
    send_byte(8'hDE, a);
    chk(!a, "R1 byte without START not acked", a, 0);
  endtask

  task automatic t_powerup();
    bit a;
    powerup_busy = 1'b1;
    bus_start(); send_byte(8'hDE, a);
    chk(!a, "R10 START during power-up ignored", a, 0);
    bus_stop();
    powerup_busy = 1'b0; wq();
  endtask

  task automatic t_cur_read();
    bit a; logic [7:0] d;
    bus_start(); send_byte(8'hDF, a);
    chk(a, "R2 control id read acked", a, 1);
    chk(reg_sel == 1'b0, "R2 control window selected", reg_sel, 0);
    recv_byte(1'b0, d);
    chk(d == model_rd(1'b0, 8'h00), "R9 current read from 00h", d, model_rd(1'b0, 8'h00));
    chk(d == model_rd(1'b0, 8'h00), "R6 read data MSB first", d, model_rd(1'b0, 8'h00));
    bus_stop();
    chk(reg_addr == 8'h01, "R7 pointer advanced after read", reg_addr, 1);
  endtask

  task automatic t_write_ctl();
    bit a1, a2, a3; int n0;
    n0 = wn;
    bus_start(); send_byte(8'hDE, a1); send_byte(8'h10, a2); send_byte(8'h33, a3); bus_stop();
    chk(a1 && a2 && a3, "R4 write bytes acked", {a1, a2, a3}, 7);
    chk(wn == n0 + 1, "R4 one strobe per byte", wn - n0, 1);
    chk(w_addr[n0] == 8'h10 && w_data[n0] == 8'h33 && w_sel[n0] == 1'b0,
        "R4 strobe address/data", {w_addr[n0], w_data[n0]}, 16'h1033);
  endtask

  task automatic t_write_mem_wrap();
    bit a; int n0; logic [7:0] ea [3]; logic [7:0] ed [3];
    ea = '{8'h2E, 8'h2F, 8'h00}; ed = '{8'h11, 8'h22, 8'h33};
    n0 = wn;
    bus_start(); send_byte(8'hAE, a);
    chk(a, "R3 memory id acked", a, 1);
    chk(reg_sel == 1'b1, "R3 memory window selected", reg_sel, 1);
    send_byte(8'h2E, a);
    for (int i = 0; i < 3; i++) send_byte(ed[i], a);
    bus_stop();
    chk(wn == n0 + 3, "R5 three strobes", wn - n0, 3);
    for (int i = 0; i < 3; i++)
      chk(w_addr[n0+i] == ea[i] && w_data[n0+i] == ed[i] && w_sel[n0+i] == 1'b1,
          "R5 write pointer wrap", w_addr[n0+i], ea[i]);
  endtask

  task automatic t_read_wrap();
    bit a1, a2, a3; logic [7:0] d; logic [7:0] ea [3];
    ea = '{8'h2E, 8'h2F, 8'h00};
    bus_start(); send_byte(8'hDE, a1); send_byte(8'h2E, a2);
    bus_start(); send_byte(8'hDF, a3);
    chk(a1 && a2 && a3, "R6 random read header acked", {a1, a2, a3}, 7);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i < 2, d);
      chk(d == model_rd(1'b0, ea[i]), "R7 burst read wrap", d, model_rd(1'b0, ea[i]));
    end
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R7 released after master NACK", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start(); send_byte(8'hDE, a); send_byte(8'h05, a);
    bus_start(); send_byte(8'hAF, a);
    chk(!a, "R8 read id differs from dummy write", a, 0);
    bus_stop();
  endtask

  task automatic t_unknown_id();
    bit a;
    bus_start(); send_byte(8'h90, a);
    chk(!a, "R3 unknown id not acked", a, 0);
    send_byte(8'hDE, a);
    chk(!a, "R3 later byte not acked", a, 0);
    bus_stop();
  endtask

  task automatic t_stop_mid();
    bit a;
    bus_start(); send_byte(8'hDE, a); send_byte(8'h07, a); bus_stop();
    send_byte(8'h55, a);
    chk(!a, "R1 STOP returns to idle", a, 0);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(posedge clk); #1;
    rst_n = 1'b1; wq();
    t_reset();
    t_no_start();
    t_powerup();
    t_cur_read();
    t_write_ctl();
    t_write_mem_wrap();
    t_read_wrap();
    t_mismatch();
    t_unknown_id();
    t_stop_mid();
    chk(oe_viol == 0, "R11 sda_oe changed while SCL high", oe_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule